// File: doc/BRIEF.md
# Vertical-First Element Step Unit

This block keeps the two element indices used when vector instructions run in vertical-first fashion: a source-element index and a destination-element index. Ordinary vector instructions read these indices but never move them. The indices move only when the decoder issues the explicit step operation, which it marks by raising `op_vf` with `op_vs` and `op_ms` both low.

On a step, each index jumps to the next element below the current vector length whose bit in its own predicate mask is set. The source and destination masks are searched independently. When either index has no such element left, the loop is over. Both indices then fold back to 0 and the step reports the end condition.

The same step can also return either index to a destination register, selected by the immediate. It can also set a condition field, either with the end-of-vector test or with one of four externally supplied loop-end triples picked by the immediate. Every effect of a step becomes visible on the clock edge that accepts it.

Top module: `vf_step_unit`

## Requirements
- R1: A step is accepted only when `issue`=1, `op_vf`=1, `op_vs`=0 and `op_ms`=0. Any other combination leaves both indices unchanged and raises neither `rt_we` nor `cr_we` in the following cycle.
- R2: Without an accepted step, a VL write or a reset, `srcstep` and `dststep` keep their values from cycle to cycle.
- R3: On an accepted step, `srcstep` becomes the smallest index greater than its current value that is below `vl` and has a 1 in `src_mask`. `dststep` is found the same way from `dst_mask`, independently of `srcstep`. Mask bits at or above `vl` are ignored.
- R4: If either search finds no such index, both `srcstep` and `dststep` become 0 and the step counts as end-of-vector.
- R5: With `vl`=0, a step leaves both indices at 0 and counts as end-of-vector.
- R6: A step with `rt_num`≠0 and `imm`=5 pulses `rt_we` for one cycle, with `rt_data` equal to the new `srcstep` zero-extended. With `imm`=6, `rt_data` carries the new `dststep` instead. With `rt_num`=0, or any other `imm`, `rt_we` stays 0. The raw field value of `imm` is used, with no offset.
- R7: A step with `rc`=1 pulses `cr_we` for one cycle; with `rc`=0 it does not. For `imm` outside 1..4 the condition bits are `cr_eq`=end, `cr_le`=end and `cr_gt`=not end.
- R8: For `imm`=k in 1..4, let s=k-1. Then `cr_eq`=`loop_end[3s]`, `cr_le`=`loop_end[3s+1]` and `cr_gt`=`loop_end[3s+2]`.
- R9: A synchronous `rst` clears both indices and both enables. A `vl_wr` pulse clears both indices and takes priority over a step in the same cycle, which then has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | An instruction is presented this cycle |
| op_vf | input | 1 | Decoded vertical-first flag |
| op_vs | input | 1 | Decoded set-VL flag |
| op_ms | input | 1 | Decoded set-MVL flag |
| imm | input | 7 | Immediate field selecting the result or the condition source |
| rt_num | input | 5 | Destination register number; 0 means none |
| rc | input | 1 | Request to update the condition field |
| vl | input | VW | Current vector length |
| vl_wr | input | 1 | A new VL is being written this cycle |
| src_mask | input | MAXEL | Source predicate mask |
| dst_mask | input | MAXEL | Destination predicate mask |
| loop_end | input | 12 | Four loop-end triples (EQ, LE, GT bits per set) |
| srcstep | output | SW | Current source-element index |
| dststep | output | SW | Current destination-element index |
| rt_we | output | 1 | Register result valid |
| rt_data | output | XLEN | Register result value |
| cr_we | output | 1 | Condition bits valid |
| cr_eq | output | 1 | Condition EQ bit |
| cr_le | output | 1 | Condition LE bit |
| cr_gt | output | 1 | Condition GT bit |

## Verification
The assertions check on every cycle that the indices hold still between steps and that a VL write clears them. They also check that every index reached by a step is either 0 or an active mask position below the old VL, and that the result and condition enables never fire without an accepted step or with RT equal to 0. Only the bench scenarios can show the exact sequence of indices for particular masks, and the point at which the end condition triggers a wrap. The same holds for the value returned for each immediate and for the selection among the four loop-end triples.

// File: rtl/vf_step_unit.sv
module vf_step_unit #(
  parameter int MAXEL = 64,
  parameter int XLEN  = 64,
  localparam int SW = $clog2(MAXEL),
  localparam int VW = SW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             op_vf,
  input  logic             op_vs,
  input  logic             op_ms,
  input  logic [6:0]       imm,
  input  logic [4:0]       rt_num,
  input  logic             rc,
  input  logic [VW-1:0]    vl,
  input  logic             vl_wr,
  input  logic [MAXEL-1:0] src_mask,
  input  logic [MAXEL-1:0] dst_mask,
  input  logic [11:0]      loop_end,
  output logic [SW-1:0]    srcstep,
  output logic [SW-1:0]    dststep,
  output logic             rt_we,
  output logic [XLEN-1:0]  rt_data,
  output logic             cr_we,
  output logic             cr_eq,
  output logic             cr_le,
  output logic             cr_gt
);

  function automatic logic [SW:0] find_next(input logic [SW-1:0] cur,
                                            input logic [MAXEL-1:0] m,
                                            input logic [VW-1:0] lim);
    logic [SW:0] r;
    logic [VW-1:0] jj;
    r = '0;
    for (int j = MAXEL - 1; j >= 0; j--) begin
      jj = VW'(j);
      if (jj > {1'b0, cur} && jj < lim && m[j]) r = {1'b1, jj[SW-1:0]};
    end
    return r;
  endfunction

  logic [SW:0]   src_nx, dst_nx;
  logic [SW-1:0] src_new, dst_new;
  logic          at_end, step, loop_sel;
  logic [1:0]    set_idx;
  logic [2:0]    set_bits;

  assign step = issue & op_vf & ~op_vs & ~op_ms;

  always_comb begin
    src_nx = find_next(srcstep, src_mask, vl);
    dst_nx = find_next(dststep, dst_mask, vl);
  end

  assign at_end   = ~src_nx[SW] | ~dst_nx[SW];
  assign src_new  = at_end ? '0 : src_nx[SW-1:0];
  assign dst_new  = at_end ? '0 : dst_nx[SW-1:0];
  assign loop_sel = (imm >= 7'd1) && (imm <= 7'd4);
  assign set_idx  = imm[1:0] - 2'd1;
  assign set_bits = 3'(loop_end >> (3 * set_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      srcstep <= '0;
      dststep <= '0;
      rt_we   <= 1'b0;
      rt_data <= '0;
      cr_we   <= 1'b0;
      cr_eq   <= 1'b0;
      cr_le   <= 1'b0;
      cr_gt   <= 1'b0;
    end else begin
      rt_we <= 1'b0;
      cr_we <= 1'b0;
      if (vl_wr) begin
        srcstep <= '0;
        dststep <= '0;
      end else if (step) begin
        srcstep <= src_new;
        dststep <= dst_new;
        rt_we   <= (rt_num != 5'd0) && (imm == 7'd5 || imm == 7'd6);
        rt_data <= (imm == 7'd6) ? XLEN'(dst_new) : XLEN'(src_new);
        cr_we   <= rc;
        if (loop_sel) begin
          cr_eq <= set_bits[0];
          cr_le <= set_bits[1];
          cr_gt <= set_bits[2];
        end else begin
          cr_eq <= at_end;
          cr_le <= at_end;
          cr_gt <= ~at_end;
        end
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!step && !vl_wr) |=> ($stable(srcstep) && $stable(dststep)));

  assert_vl_clear_R9: assert property (@(posedge clk) disable iff (rst)
    vl_wr |=> (srcstep == '0 && dststep == '0));

  assert_src_active_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !vl_wr) |=> (srcstep == '0 ||
      ((($past(src_mask) >> srcstep) & MAXEL'(1)) != '0 && {1'b0, srcstep} < $past(vl))));

  assert_dst_active_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !vl_wr) |=> (dststep == '0 ||
      ((($past(dst_mask) >> dststep) & MAXEL'(1)) != '0 && {1'b0, dststep} < $past(vl))));

  assert_no_effect_R1: assert property (@(posedge clk) disable iff (rst)
    (!step || vl_wr) |=> (!rt_we && !cr_we));

  assert_rt_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !vl_wr && rt_num == 5'd0) |=> !rt_we);

endmodule

// File: tb/tb_vf_step_unit.sv
module tb_vf_step_unit;
  localparam int MAXEL = 64;
  localparam int XLEN  = 64;
  localparam int SW = $clog2(MAXEL);
  localparam int VW = SW + 1;

  logic clk = 0, rst = 1, issue = 0, op_vf = 0, op_vs = 0, op_ms = 0, rc = 0, vl_wr = 0;
  logic [6:0] imm = '0;
  logic [4:0] rt_num = '0;
  logic [VW-1:0] vl = '0;
  logic [MAXEL-1:0] src_mask = '1, dst_mask = '1;
  logic [11:0] loop_end = '0;
  logic [SW-1:0] srcstep, dststep;
  logic rt_we, cr_we, cr_eq, cr_le, cr_gt;
  logic [XLEN-1:0] rt_data;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vf_step_unit #(.MAXEL(MAXEL), .XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .issue(issue), .op_vf(op_vf), .op_vs(op_vs), .op_ms(op_ms),
    .imm(imm), .rt_num(rt_num), .rc(rc), .vl(vl), .vl_wr(vl_wr),
    .src_mask(src_mask), .dst_mask(dst_mask), .loop_end(loop_end),
    .srcstep(srcstep), .dststep(dststep), .rt_we(rt_we), .rt_data(rt_data),
    .cr_we(cr_we), .cr_eq(cr_eq), .cr_le(cr_le), .cr_gt(cr_gt));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idx(input string req, input int s, input int d);
    chk(req, "srcstep", 64'(srcstep), 64'(s));
    chk(req, "dststep", 64'(dststep), 64'(d));
  endtask

  task automatic op(input logic vf, input logic vs, input logic ms,
                    input logic [6:0] i, input logic [4:0] r, input logic c);
    @(negedge clk);
    issue = 1; op_vf = vf; op_vs = vs; op_ms = ms; imm = i; rt_num = r; rc = c;
    @(posedge clk); #1;
    issue = 0; op_vf = 0; op_vs = 0; op_ms = 0; imm = 0; rt_num = 0; rc = 0;
  endtask

  task automatic stp(input logic [6:0] i, input logic [4:0] r, input logic c);
    op(1, 0, 0, i, r, c);
  endtask

  task automatic set_vl(input int v);
    @(negedge clk);
    vl = VW'(v); vl_wr = 1;
    @(posedge clk); #1;
    vl_wr = 0;
  endtask

  task automatic t_reset;
    chk("R9", "reset srcstep", 64'(srcstep), 0);
    chk("R9", "reset dststep", 64'(dststep), 0);
    chk("R9", "reset rt_we", 64'(rt_we), 0);
    chk("R9", "reset cr_we", 64'(cr_we), 0);
  endtask

  task automatic t_full_mask;
    src_mask = '1; dst_mask = '1; set_vl(4);
    stp(5, 3, 0);
    chk_idx("R3", 1, 1);
    chk("R6", "rt_we src", 64'(rt_we), 1);
    chk("R6", "rt_data src", rt_data, 1);
    chk("R7", "cr_we rc0", 64'(cr_we), 0);
    stp(6, 3, 0);
    chk("R6", "rt_data dst", rt_data, 2);
    stp(0, 0, 1);
    chk_idx("R3", 3, 3);
    chk("R7", "cr_we", 64'(cr_we), 1);
    chk("R7", "eq/le/gt mid", {61'd0, cr_eq, cr_le, cr_gt}, 3'b001);
    stp(0, 0, 1);
    chk_idx("R4", 0, 0);
    chk("R4", "eq/le/gt end", {61'd0, cr_eq, cr_le, cr_gt}, 3'b110);
    chk("R6", "rt_we none", 64'(rt_we), 0);
  endtask

  task automatic t_masks;
    src_mask = 64'hA5; dst_mask = 64'h1A; set_vl(8);
    stp(6, 7, 0);
    chk_idx("R3", 2, 1);
    chk("R6", "rt_data dst", rt_data, 1);
    stp(5, 7, 0);
    chk_idx("R3", 5, 3);
    chk("R6", "rt_data src", rt_data, 5);
    stp(0, 0, 0);
    chk_idx("R3", 7, 4);
    stp(0, 0, 1);
    chk_idx("R4", 0, 0);
    chk("R4", "eq end", 64'(cr_eq), 1);
  endtask

  task automatic t_non_step;
    src_mask = '1; dst_mask = '1; set_vl(8);
    stp(0, 0, 0); stp(0, 0, 0);
    op(1, 1, 0, 5, 3, 1);
    chk_idx("R1", 2, 2);
    chk("R1", "vs rt_we", 64'(rt_we), 0);
    chk("R1", "vs cr_we", 64'(cr_we), 0);
    op(0, 0, 0, 5, 3, 1);
    chk_idx("R1", 2, 2);
    chk("R1", "vf0 cr_we", 64'(cr_we), 0);
    op(1, 0, 1, 6, 3, 1);
    chk_idx("R1", 2, 2);
    chk("R1", "ms rt_we", 64'(rt_we), 0);
    @(negedge clk); op_vf = 1; imm = 5; rt_num = 3; rc = 1;
    repeat (3) @(posedge clk); #1;
    op_vf = 0; imm = 0; rt_num = 0; rc = 0;
    chk_idx("R2", 2, 2);
    chk("R2", "idle cr_we", 64'(cr_we), 0);
  endtask

  task automatic t_vl_zero;
    set_vl(0);
    stp(5, 3, 1);
    chk_idx("R5", 0, 0);
    chk("R5", "rt_data", rt_data, 0);
    chk("R5", "cr_eq", 64'(cr_eq), 1);
    chk("R5", "cr_gt", 64'(cr_gt), 0);
  endtask

  task automatic t_loop_sets;
    src_mask = '1; dst_mask = '1; set_vl(16);
    loop_end = 12'b101_011_110_001;
    stp(1, 0, 1);
    chk("R8", "set0", {61'd0, cr_eq, cr_le, cr_gt}, 3'b100);
    stp(2, 0, 1);
    chk("R8", "set1", {61'd0, cr_eq, cr_le, cr_gt}, 3'b011);
    stp(3, 0, 1);
    chk("R8", "set2", {61'd0, cr_eq, cr_le, cr_gt}, 3'b110);
    stp(4, 0, 1);
    chk("R8", "set3", {61'd0, cr_eq, cr_le, cr_gt}, 3'b101);
    chk_idx("R3", 4, 4);
  endtask

  task automatic t_priority;
    src_mask = '1; dst_mask = '1; set_vl(4);
    stp(0, 0, 0);
    chk_idx("R3", 1, 1);
    @(negedge clk);
    vl_wr = 1; issue = 1; op_vf = 1; imm = 5; rt_num = 3; rc = 1;
    @(posedge clk); #1;
    vl_wr = 0; issue = 0; op_vf = 0; imm = 0; rt_num = 0; rc = 0;
    chk_idx("R9", 0, 0);
    chk("R9", "rt_we on vl_wr", 64'(rt_we), 0);
    chk("R9", "cr_we on vl_wr", 64'(cr_we), 0);
    stp(5, 0, 0);
    chk("R6", "rt0 rt_we", 64'(rt_we), 0);
    stp(0, 0, 0);
    @(negedge clk); rst = 1;
    @(posedge clk); #1; rst = 0;
    chk_idx("R9", 0, 0);
  endtask

  task automatic t_above_vl;
    src_mask = '1; dst_mask = '1; set_vl(3);
    stp(0, 0, 0); stp(0, 0, 0);
    chk_idx("R3", 2, 2);
    stp(0, 0, 1);
    chk_idx("R4", 0, 0);
    chk("R4", "eq above vl", 64'(cr_eq), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 0;
    t_full_mask();
    t_masks();
    t_non_step();
    t_vl_zero();
    t_loop_sets();
    t_priority();
    t_above_vl();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule